// File: doc/BRIEF.md
# Radix-8 64-Point FFT Engine

This block computes the forward discrete Fourier transform of a frame of 64 complex fixed-point samples. The length is split as 8 × 8, so the work takes two passes of eight 8-point butterflies each, with a twiddle multiply between the passes. One combinational 8-point butterfly is shared by both passes, and it handles one group per clock cycle. A register-based working store holds the frame in place. Twiddle factors come from a quarter-wave cosine table, and each of the 64th roots of unity is folded out of that table by quadrant.

Samples arrive in natural order on a valid/ready stream. When the 64th sample is taken, the engine closes its input and runs the two passes in 16 cycles. It then streams the 64 bins out in natural order with a last marker. Each pass divides by 8 with round-half-up, so every bin equals the DFT divided by 64. A new frame is taken only after the last bin of the previous frame has been handed over.

Top module: `fft64_r8`

## Requirements
- R1: `in_ready` is high only while a frame is being collected. A sample is taken on a clock edge where `in_valid` and `in_ready` are both high, and a cycle with `in_valid` low takes nothing. `in_ready` is low in the cycle after the edge that takes the 64th sample.
- R2: No sample of the next frame is taken before the 64th bin of the current frame has been handed over. `in_ready` and `out_valid` are never high together. `in_ready` is high again in the cycle after the handshake that carries `out_last`.
- R3: Bins leave in natural order 0, 1, …, 63, one per `out_valid`/`out_ready` handshake. `out_last` is high with bin 63 and with no other bin.
- R4: Bin k has real and imaginary parts within ±4 LSB of round((1/64)·Σₙ x[n]·W^(nk)), where W = cos(2π/64) − j·sin(2π/64). This holds for inputs whose real and imaginary parts each lie in [−16383, 16383] as 16-bit two's complement. The intermediate results stay inside 16 bits.
- R5: An impulse of value A at sample 0 gives A/64 in every bin. A constant frame of value C gives C in bin 0 and zero in every other bin, each within ±4 LSB.
- R6: For a period-16 frame (eight samples of 4096, four of 8192, four of 0, repeated four times), every bin whose index is not a multiple of 4 is within ±4 LSB of zero.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_re` and `out_im` hold their values into the next cycle.
- R8: `out_valid` rises on the 16th clock edge after the edge that takes the 64th sample.
- R9: After reset is released, `in_ready` is high and `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| in_valid | input | 1 | Input sample is valid |
| in_ready | output | 1 | Engine is collecting a frame |
| in_re | input | 16 | Input sample, real part, signed |
| in_im | input | 16 | Input sample, imaginary part, signed |
| out_valid | output | 1 | Output bin is valid |
| out_ready | input | 1 | Consumer takes the bin |
| out_re | output | 16 | Output bin, real part, signed |
| out_im | output | 16 | Output bin, imaginary part, signed |
| out_last | output | 1 | Marks bin 63 |

## Verification
The overflow assertion takes for granted that every input component lies within ±16383. Under that bound, the sums after each scaled pass and after the twiddle rotation cannot leave 16 bits. The stimulus keeps to the bound: the random frames are limited to ±12000 per component, the tone has amplitude 12000, and the impulse, constant and periodic frames sit well inside it. The handshake assertions assume that the consumer may hold `out_ready` low for any number of cycles. The bench does this on a fixed rhythm and also inserts idle cycles in `in_valid`.

// File: rtl/fft_pkg.sv
package fft_pkg;

  localparam int TW_W    = 16;
  localparam int TW_FRAC = 14;

  typedef enum logic [1:0] {
    ST_LOAD  = 2'd0,
    ST_PASS1 = 2'd1,
    ST_PASS2 = 2'd2,
    ST_DRAIN = 2'd3
  } fft_state_e;

  // cos(2*pi*i/64) in Q2.14 for i = 0..16
  function automatic logic signed [TW_W-1:0] quarter_cos(input logic [4:0] i);
    logic signed [TW_W-1:0] c;
    case (i)
      5'd0:  c = 16'sd16384;
      5'd1:  c = 16'sd16305;
      5'd2:  c = 16'sd16069;
      5'd3:  c = 16'sd15679;
      5'd4:  c = 16'sd15137;
      5'd5:  c = 16'sd14449;
      5'd6:  c = 16'sd13623;
      5'd7:  c = 16'sd12665;
      5'd8:  c = 16'sd11585;
      5'd9:  c = 16'sd10394;
      5'd10: c = 16'sd9102;
      5'd11: c = 16'sd7723;
      5'd12: c = 16'sd6270;
      5'd13: c = 16'sd4756;
      5'd14: c = 16'sd3196;
      5'd15: c = 16'sd1606;
      default: c = 16'sd0;
    endcase
    return c;
  endfunction

  // W^k = cos(2*pi*k/64) - j*sin(2*pi*k/64), returned as {re, im}
  function automatic logic [2*TW_W-1:0] root_of_unity(input logic [5:0] k);
    logic signed [TW_W-1:0] c, s, wr, wi;
    c = quarter_cos({1'b0, k[3:0]});
    s = quarter_cos(5'd16 - {1'b0, k[3:0]});
    case (k[5:4])
      2'd0: begin wr =  c; wi = -s; end
      2'd1: begin wr = -s; wi = -c; end
      2'd2: begin wr = -c; wi =  s; end
      default: begin wr = s; wi = c; end
    endcase
    return {wr, wi};
  endfunction

endpackage

// File: rtl/fft_r8_bfly.sv
module fft_r8_bfly #(
  parameter int DW = 16
) (
  input  logic signed [DW-1:0] x_re [8],
  input  logic signed [DW-1:0] x_im [8],
  output logic signed [DW-1:0] y_re [8],
  output logic signed [DW-1:0] y_im [8],
  output logic                 ovf
);

  localparam int IW = DW + 6;
  localparam int PW = IW + 16;
  localparam logic signed [PW-1:0] HALF_ROOT2 = PW'(23170);
  localparam logic signed [PW-1:0] RND_Q15    = PW'(16384);
  localparam logic signed [IW-1:0] LIM_HI     = IW'((1 << (DW-1)) - 1);
  localparam logic signed [IW-1:0] LIM_LO     = IW'(-(1 << (DW-1)));
  localparam logic signed [IW-1:0] RND_DIV8   = IW'(4);

  function automatic logic signed [IW-1:0] mul_hr2(input logic signed [IW-1:0] v);
    logic signed [PW-1:0] p;
    p = PW'(v) * HALF_ROOT2 + RND_Q15;
    return IW'(p >>> 15);
  endfunction

  // multiply (ar + j ai) by the e-th 8th root of unity
  function automatic void rot8(input  logic signed [IW-1:0] ar,
                               input  logic signed [IW-1:0] ai,
                               input  int                   e,
                               output logic signed [IW-1:0] br,
                               output logic signed [IW-1:0] bi);
    case (e)
      1: begin br = mul_hr2(ar + ai);  bi = mul_hr2(ai - ar);  end
      2: begin br = ai;                bi = -ar;               end
      3: begin br = mul_hr2(ai - ar);  bi = -mul_hr2(ar + ai); end
      default: begin br = ar; bi = ai; end
    endcase
  endfunction

  logic signed [IW-1:0] vr [8];
  logic signed [IW-1:0] vi [8];
  logic signed [IW-1:0] sr [8];
  logic signed [IW-1:0] si [8];
  logic signed [IW-1:0] dr, di;

  always_comb begin
    dr  = '0;
    di  = '0;
    ovf = 1'b0;
    for (int i = 0; i < 8; i++) begin
      vr[i] = IW'(x_re[i]);
      vi[i] = IW'(x_im[i]);
    end
    // three radix-2 DIF layers, span 4, 2, 1
    for (int st = 0; st < 3; st++) begin
      for (int b = 0; b < 8; b++) begin
        if ((b & (4 >> st)) == 0) begin
          dr = vr[b] - vr[b + (4 >> st)];
          di = vi[b] - vi[b + (4 >> st)];
          vr[b] = vr[b] + vr[b + (4 >> st)];
          vi[b] = vi[b] + vi[b + (4 >> st)];
          rot8(dr, di, (b & ((4 >> st) - 1)) << st, vr[b + (4 >> st)], vi[b + (4 >> st)]);
        end
      end
    end
    // bit-reversed unscramble and divide by 8
    for (int k = 0; k < 8; k++) begin
      sr[k] = (vr[{k[0], k[1], k[2]}] + RND_DIV8) >>> 3;
      si[k] = (vi[{k[0], k[1], k[2]}] + RND_DIV8) >>> 3;
      if (sr[k] > LIM_HI || sr[k] < LIM_LO || si[k] > LIM_HI || si[k] < LIM_LO)
        ovf = 1'b1;
      y_re[k] = DW'(sr[k]);
      y_im[k] = DW'(si[k]);
    end
  end

endmodule

// File: rtl/fft_twiddle.sv
module fft_twiddle #(
  parameter int DW = 16
) (
  input  logic signed [DW-1:0] a_re,
  input  logic signed [DW-1:0] a_im,
  input  logic [5:0]           k,
  output logic signed [DW-1:0] y_re,
  output logic signed [DW-1:0] y_im
);

  localparam int PW = DW + fft_pkg::TW_W + 1;
  localparam logic signed [PW-1:0] RND = PW'(1 << (fft_pkg::TW_FRAC - 1));

  logic signed [fft_pkg::TW_W-1:0] wr, wi;
  logic signed [PW-1:0]            pr, pi;

  always_comb begin
    {wr, wi} = fft_pkg::root_of_unity(k);
    pr = PW'(a_re) * PW'(wr) - PW'(a_im) * PW'(wi) + RND;
    pi = PW'(a_re) * PW'(wi) + PW'(a_im) * PW'(wr) + RND;
    y_re = DW'(pr >>> fft_pkg::TW_FRAC);
    y_im = DW'(pi >>> fft_pkg::TW_FRAC);
  end

endmodule

// File: rtl/fft_store.sv
module fft_store #(
  parameter int DW    = 16,
  parameter int DEPTH = 64,
  parameter int PORTS = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic                 clk,
  input  logic [PORTS-1:0]     wr_en,
  input  logic [AW-1:0]        wr_addr [PORTS],
  input  logic signed [DW-1:0] wr_re   [PORTS],
  input  logic signed [DW-1:0] wr_im   [PORTS],
  input  logic [AW-1:0]        rd_addr [PORTS],
  output logic signed [DW-1:0] rd_re   [PORTS],
  output logic signed [DW-1:0] rd_im   [PORTS]
);

  logic signed [DW-1:0] mem_re [DEPTH];
  logic signed [DW-1:0] mem_im [DEPTH];

  always_ff @(posedge clk) begin
    for (int p = 0; p < PORTS; p++) begin
      if (wr_en[p]) begin
        mem_re[wr_addr[p]] <= wr_re[p];
        mem_im[wr_addr[p]] <= wr_im[p];
      end
    end
  end

  for (genvar g = 0; g < PORTS; g++) begin : g_rd
    assign rd_re[g] = mem_re[rd_addr[g]];
    assign rd_im[g] = mem_im[rd_addr[g]];
  end

endmodule

// File: rtl/fft64_r8.sv
module fft64_r8 #(
  parameter int DW = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic signed [DW-1:0] in_re,
  input  logic signed [DW-1:0] in_im,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic signed [DW-1:0] out_re,
  output logic signed [DW-1:0] out_im,
  output logic                 out_last
);
  import fft_pkg::*;

  localparam int RADIX = 8;
  localparam int NPTS  = RADIX * RADIX;
  localparam int AW    = $clog2(NPTS);
  localparam int GW    = $clog2(RADIX);
  localparam logic [AW-1:0] CNT_END = AW'(NPTS - 1);
  localparam logic [AW-1:0] GRP_END = AW'(RADIX - 1);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_q;
  logic       rst_sn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 2'b00;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_sn = rst_q[1];

  // control
  fft_state_e    state_q, state_d;
  logic [AW-1:0] cnt_q, cnt_d;
  logic [GW-1:0] grp;
  logic          in_pass;

  assign grp     = cnt_q[GW-1:0];
  assign in_pass = (state_q == ST_PASS1) || (state_q == ST_PASS2);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    case (state_q)
      ST_LOAD: if (in_valid) begin
        cnt_d = cnt_q + 1'b1;
        if (cnt_q == CNT_END) begin state_d = ST_PASS1; cnt_d = '0; end
      end
      ST_PASS1: begin
        cnt_d = cnt_q + 1'b1;
        if (cnt_q == GRP_END) begin state_d = ST_PASS2; cnt_d = '0; end
      end
      ST_PASS2: begin
        cnt_d = cnt_q + 1'b1;
        if (cnt_q == GRP_END) begin state_d = ST_DRAIN; cnt_d = '0; end
      end
      default: if (out_ready) begin
        cnt_d = cnt_q + 1'b1;
        if (cnt_q == CNT_END) begin state_d = ST_LOAD; cnt_d = '0; end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      state_q <= ST_LOAD;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  // datapath
  logic [RADIX-1:0]     wr_en;
  logic [AW-1:0]        wr_addr [RADIX];
  logic signed [DW-1:0] wr_re   [RADIX];
  logic signed [DW-1:0] wr_im   [RADIX];
  logic [AW-1:0]        rd_addr [RADIX];
  logic signed [DW-1:0] rd_re   [RADIX];
  logic signed [DW-1:0] rd_im   [RADIX];
  logic signed [DW-1:0] bf_re   [RADIX];
  logic signed [DW-1:0] bf_im   [RADIX];
  logic signed [DW-1:0] tw_re   [RADIX];
  logic signed [DW-1:0] tw_im   [RADIX];
  logic [AW-1:0]        tw_k    [RADIX];
  logic                 bf_ovf;

  for (genvar g = 0; g < RADIX; g++) begin : g_lane
    // pass 1 gathers a stride-8 group, pass 2 a contiguous one
    if (g == 0) begin : g_port0
      always_comb begin
        case (state_q)
          ST_PASS1: rd_addr[g] = {GW'(g), grp};
          ST_PASS2: rd_addr[g] = {grp, GW'(g)};
          default:  rd_addr[g] = {cnt_q[GW-1:0], cnt_q[AW-1:GW]};
        endcase
        wr_en[g]   = in_pass || (state_q == ST_LOAD && in_valid);
        wr_addr[g] = (state_q == ST_LOAD) ? cnt_q : rd_addr[g];
        wr_re[g]   = (state_q == ST_LOAD) ? in_re : tw_re[g];
        wr_im[g]   = (state_q == ST_LOAD) ? in_im : tw_im[g];
      end
    end else begin : g_portn
      always_comb begin
        rd_addr[g] = (state_q == ST_PASS1) ? {GW'(g), grp} : {grp, GW'(g)};
        wr_en[g]   = in_pass;
        wr_addr[g] = rd_addr[g];
        wr_re[g]   = tw_re[g];
        wr_im[g]   = tw_im[g];
      end
    end

    assign tw_k[g] = (state_q == ST_PASS1) ? ({{(AW-GW){1'b0}}, grp} * AW'(g)) : '0;

    fft_twiddle #(.DW(DW)) u_tw (
      .a_re (bf_re[g]),
      .a_im (bf_im[g]),
      .k    (tw_k[g]),
      .y_re (tw_re[g]),
      .y_im (tw_im[g])
    );
  end

  fft_r8_bfly #(.DW(DW)) u_bfly (
    .x_re (rd_re),
    .x_im (rd_im),
    .y_re (bf_re),
    .y_im (bf_im),
    .ovf  (bf_ovf)
  );

  fft_store #(.DW(DW), .DEPTH(NPTS), .PORTS(RADIX)) u_store (
    .clk     (clk),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_re   (wr_re),
    .wr_im   (wr_im),
    .rd_addr (rd_addr),
    .rd_re   (rd_re),
    .rd_im   (rd_im)
  );

  assign in_ready  = (state_q == ST_LOAD);
  assign out_valid = (state_q == ST_DRAIN);
  assign out_last  = (state_q == ST_DRAIN) && (cnt_q == CNT_END);
  assign out_re    = rd_re[0];
  assign out_im    = rd_im[0];

  // checks
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_sn)
    in_pass |-> !bf_ovf) else $error("butterfly overflow"); // R4

  AST_INPUT_CLOSES: assert property (@(posedge clk) disable iff (!rst_sn)
    (in_valid && in_ready && cnt_q == CNT_END) |=> !in_ready) else $error("input not closed"); // R1

  AST_READY_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_sn)
    in_ready |-> !out_valid) else $error("ready and valid together"); // R2

  AST_REOPEN_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_sn)
    (out_valid && out_ready && out_last) |=> (in_ready && !out_valid)) else $error("no reopen"); // R2

  AST_LAST_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_sn)
    out_last |-> out_valid) else $error("stray last"); // R3

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_sn)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_re) && $stable(out_im) && $stable(out_last)))
    else $error("output moved under backpressure"); // R7

  AST_DRAIN_AFTER_PASSES: assert property (@(posedge clk) disable iff (!rst_sn)
    $rose(out_valid) |-> $past(state_q) == ST_PASS2) else $error("early output"); // R8

endmodule

// File: tb/sim_fft64_r8.sv
module sim_fft64_r8;
  localparam int DW  = 16;
  localparam int TOL = 4;

  logic                 clk;
  logic                 rst_n;
  logic                 in_valid;
  logic                 in_ready;
  logic signed [DW-1:0] in_re, in_im;
  logic                 out_valid;
  logic                 out_ready;
  logic signed [DW-1:0] out_re, out_im;
  logic                 out_last;

  fft64_r8 #(.DW(DW)) u0 (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_re(in_re), .in_im(in_im),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_re(out_re), .out_im(out_im), .out_last(out_last)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  typedef struct {
    int    re;
    int    im;
    int    bin;
    bit    periodic;
    string req;
  } exp_t;

  exp_t sb[$];
  int   errors = 0;
  int   checks = 0;
  int   fr_re[64];
  int   fr_im[64];
  int unsigned seed = 32'h1234_5678;

  function automatic int iabs(int v);
    return (v < 0) ? -v : v;
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int rnd12k();
    seed = seed * 32'd1103515245 + 32'd12345;
    return int'((seed >> 8) % 24001) - 12000;
  endfunction

  // driver: pushes the reference spectrum, then streams the frame
  task automatic send_frame(string req, bit periodic);
    int lat;
    for (int k = 0; k < 64; k++) begin
      real sr, si, a;
      exp_t e;
      sr = 0.0; si = 0.0;
      for (int n = 0; n < 64; n++) begin
        a  = 2.0 * 3.14159265358979 * real'((n * k) % 64) / 64.0;
        sr = sr + real'(fr_re[n]) * $cos(a) + real'(fr_im[n]) * $sin(a);
        si = si + real'(fr_im[n]) * $cos(a) - real'(fr_re[n]) * $sin(a);
      end
      e.re = int'(sr / 64.0);
      e.im = int'(si / 64.0);
      e.bin = k;
      e.periodic = periodic;
      e.req = req;
      sb.push_back(e);
    end
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    check(sb.size() == 64, "R2", "stale bins queued when input reopened", sb.size(), 64);
    for (int i = 0; i < 64; i++) begin
      if (i % 7 == 3) begin
        in_valid = 1'b0;
        @(negedge clk);
      end
      while (!in_ready) @(negedge clk);
      in_valid = 1'b1;
      in_re = DW'(fr_re[i]);
      in_im = DW'(fr_im[i]);
      @(negedge clk);
    end
    in_valid = 1'b0;
    check(!in_ready, "R1", "in_ready after 64th sample", int'(in_ready), 0);
    lat = 1;
    while (!out_valid && lat < 100) begin
      check(!in_ready, "R2", "in_ready during passes", int'(in_ready), 0);
      @(negedge clk);
      lat++;
    end
    check(lat == 17, "R8", "edges from 64th sample to out_valid", lat - 1, 16);
  endtask

  // monitor: pops expected bins and compares; backpressure on a fixed rhythm
  initial begin : monitor
    int hold_re, hold_im;
    bit holding;
    int step;
    holding = 1'b0;
    step = 0;
    out_ready = 1'b0;
    forever begin
      @(negedge clk);
      if (holding) begin
        check(out_valid && int'(out_re) == hold_re && int'(out_im) == hold_im,
              "R7", "held bin real", int'(out_re), hold_re);
        holding = 1'b0;
      end
      step++;
      out_ready = (step % 5) != 2;
      if (out_valid && out_ready) begin
        if (sb.size() == 0) begin
          check(1'b0, "R3", "bin with empty scoreboard", 1, 0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          check(iabs(int'(out_re) - e.re) <= TOL, e.req, $sformatf("bin %0d real", e.bin), int'(out_re), e.re);
          check(iabs(int'(out_im) - e.im) <= TOL, e.req, $sformatf("bin %0d imag", e.bin), int'(out_im), e.im);
          check(out_last == (e.bin == 63), "R3", $sformatf("out_last at bin %0d", e.bin),
                int'(out_last), int'(e.bin == 63));
          if (e.periodic && (e.bin % 4) != 0) begin
            check(iabs(int'(out_re)) <= TOL && iabs(int'(out_im)) <= TOL, "R6",
                  $sformatf("bin %0d not near zero", e.bin), iabs(int'(out_re)) + iabs(int'(out_im)), 0);
          end
        end
      end else if (out_valid) begin
        holding = 1'b1;
        hold_re = int'(out_re);
        hold_im = int'(out_im);
      end
    end
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    rst_n = 1'b0;
    in_valid = 1'b0;
    in_re = '0;
    in_im = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(in_ready == 1'b1, "R9", "in_ready after reset", int'(in_ready), 1);
    check(out_valid == 1'b0, "R9", "out_valid after reset", int'(out_valid), 0);

    // impulse: flat spectrum 8000/64 = 125
    for (int n = 0; n < 64; n++) begin fr_re[n] = (n == 0) ? 8000 : 0; fr_im[n] = 0; end
    send_frame("R5", 1'b0);

    // constant: all energy in bin 0
    for (int n = 0; n < 64; n++) begin fr_re[n] = 3200; fr_im[n] = -1600; end
    send_frame("R5", 1'b0);

    // period-16 pattern
    for (int n = 0; n < 64; n++) begin
      fr_re[n] = ((n % 16) < 8) ? 4096 : (((n % 16) < 12) ? 8192 : 0);
      fr_im[n] = 0;
    end
    send_frame("R6", 1'b1);

    // complex tone at bin 5
    for (int n = 0; n < 64; n++) begin
      fr_re[n] = int'(12000.0 * $cos(2.0 * 3.14159265358979 * 5.0 * real'(n) / 64.0));
      fr_im[n] = int'(12000.0 * $sin(2.0 * 3.14159265358979 * 5.0 * real'(n) / 64.0));
    end
    send_frame("R4", 1'b0);

    // two random frames within bound
    for (int f = 0; f < 2; f++) begin
      for (int n = 0; n < 64; n++) begin fr_re[n] = rnd12k(); fr_im[n] = rnd12k(); end
      send_frame("R4", 1'b0);
    end

    while (sb.size() != 0) @(negedge clk);
    @(negedge clk);
    check(in_ready == 1'b1, "R2", "in_ready after final last", int'(in_ready), 1);
    check(out_valid == 1'b0, "R2", "out_valid after final last", int'(out_valid), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule